// File: doc/BRIEF.md
# Free-XOR Wire Label Unit

This unit keeps the garbled wire labels of a secure garbling core. Every wire carries a pair of labels of `LBL_W` bits: a one-label and a zero-label. The low bit of each label is the select bit and the remaining bits are random. The two labels of a wire are tied together by a global offset, written `{offset, 1'b1}`. XOR gates get their output labels by XORing input labels, so no encryption is needed. Update gates move a wire from the current offset to a second, next-template offset. At a template boundary the next offset is promoted to current and the next offset is cleared.

Commands come in on a valid/ready stream. Every accepted command produces exactly one response on a valid/ready stream one clock later. While a response waits, `cmd_ready` is low. The response stays frozen while `rsp_ready` is low, so back-pressure on the response side stalls the command side. The latency never depends on label values. Random words come from an external source on `rand_word` and are sampled when the command is accepted. Wire IDs are `WID_W` bits wide. Only IDs below `NUM_WIRES` are backed by storage.

Top module: `wl_label_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` is 0, both offsets are zero and no wire is written.
- R2: A new-wire command (op 1) stores one-label = `rand_word` and zero-label = `rand_word ^ {cur_offset, 1'b1}` at `cmd_dst`, and returns that pair.
- R3: An XOR command (op 2) stores zero = zero(a) ^ zero(b) and one = zero(a) ^ one(b) at `cmd_dst`, where a = `cmd_src_a` and b = `cmd_src_b`, and returns that pair.
- R4: An update command (op 3) stores zero = zero(a) and one = zero(a) ^ {next_offset, 1'b1} at `cmd_dst`, and returns that pair.
- R5: Load-current (op 4) and load-next (op 5) set the respective offset to `rand_word[LBL_W-1:1]`. Their response has `rsp_err` 0 and both labels 0.
- R6: Promote (op 6) copies the next offset into the current offset and clears the next offset.
- R7: A command that reads an unwritten source wire, reads or writes an ID at or above `NUM_WIRES`, or both, responds with `rsp_err` 1 and both labels 0, and changes no stored label or written flag.
- R8: The response of an accepted command appears on the next clock. `cmd_ready` stays low from that point until the response is taken.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields hold their values.
- R10: A read command (op 0) returns the stored pair of wire `cmd_src_a`. A no-op (op 7) returns `rsp_err` 0 and zero labels.
- R11: Every successful label response (ops 0 to 3) has zero and one labels that differ in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Command code (see R2 to R10) |
| cmd_dst | input | WID_W | Destination wire ID |
| cmd_src_a | input | WID_W | First source wire ID |
| cmd_src_b | input | WID_W | Second source wire ID |
| rand_word | input | LBL_W | Random word for new labels and offset loads |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_err | output | 1 | Command rejected, nothing written |
| rsp_zero | output | LBL_W | Zero-label of the result |
| rsp_one | output | LBL_W | One-label of the result |

## Verification
The embedded assertions check, on every cycle, the one-cycle response latency, the frozen response under back-pressure, the differing select bits of every label response, and the way the offset registers react to loads and promotion. Only the bench scenarios can show that the label arithmetic is right for each gate type. The same holds for rejected commands leaving storage untouched (a later read shows this) and for an update after promotion using a cleared next offset. The bench's reference model tracks stored pairs and both offsets itself, and it compares the handshake pins on every clock.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    OP_READ = 3'd0,
    OP_NEW  = 3'd1,
    OP_XOR  = 3'd2,
    OP_UPD  = 3'd3,
    OP_LDC  = 3'd4,
    OP_LDN  = 3'd5,
    OP_PROM = 3'd6,
    OP_NOP  = 3'd7
  } wl_op_e;
endpackage

// File: rtl/wl_offsets.sv
module wl_offsets #(
  parameter int OFS_W = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_cur,
  input  logic             ld_nxt,
  input  logic             promote,
  input  logic [OFS_W-1:0] ld_val,
  output logic [OFS_W-1:0] cur,
  output logic [OFS_W-1:0] nxt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      nxt <= '0;
    end else if (promote) begin
      cur <= nxt;
      nxt <= '0;
    end else begin
      if (ld_cur) cur <= ld_val;
      if (ld_nxt) nxt <= ld_val;
    end
  end

  // R6: promotion moves next into current and clears next
  a_r6_promote: assert property (@(posedge clk) disable iff (!rst_n)
    promote |=> (nxt == '0) && (cur == $past(nxt)));

  // R5: a load lands the sampled value
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cur && !promote) |=> cur == $past(ld_val));
endmodule

// File: rtl/wl_store.sv
module wl_store #(
  parameter int LBL_W     = 128,
  parameter int WID_W     = 16,
  parameter int NUM_WIRES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WID_W-1:0] ra_id,
  input  logic [WID_W-1:0] rb_id,
  input  logic [WID_W-1:0] wr_id,
  input  logic             wr_en,
  input  logic [LBL_W-1:0] wr_zero,
  input  logic [LBL_W-1:0] wr_one,
  output logic             ra_ok,
  output logic [LBL_W-1:0] ra_zero,
  output logic [LBL_W-1:0] ra_one,
  output logic             rb_ok,
  output logic [LBL_W-1:0] rb_zero,
  output logic [LBL_W-1:0] rb_one,
  output logic             wr_in_range
);
  localparam int IDX_W = (NUM_WIRES > 1) ? $clog2(NUM_WIRES) : 1;
  localparam logic [WID_W-1:0] LIMIT = WID_W'(NUM_WIRES);

  logic [LBL_W-1:0] mem_z [NUM_WIRES];
  logic [LBL_W-1:0] mem_o [NUM_WIRES];
  logic             vld   [NUM_WIRES];

  logic [IDX_W-1:0] ia, ib, iw;
  assign ia = ra_id[IDX_W-1:0];
  assign ib = rb_id[IDX_W-1:0];
  assign iw = wr_id[IDX_W-1:0];

  assign wr_in_range = (wr_id < LIMIT);
  assign ra_ok   = (ra_id < LIMIT) && vld[ia];
  assign rb_ok   = (rb_id < LIMIT) && vld[ib];
  assign ra_zero = mem_z[ia];
  assign ra_one  = mem_o[ia];
  assign rb_zero = mem_z[ib];
  assign rb_one  = mem_o[ib];

  for (genvar g = 0; g < NUM_WIRES; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (!rst_n)                                  vld[g] <= 1'b0;
      else if (wr_en && wr_in_range && iw == IDX_W'(g)) vld[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) begin
      mem_z[iw] <= wr_zero;
      mem_o[iw] <= wr_one;
    end
  end
endmodule

// File: rtl/wl_alu.sv
module wl_alu
  import wl_pkg::*;
#(
  parameter int LBL_W = 128
) (
  input  wl_op_e           op,
  input  logic [LBL_W-2:0] ofs_cur,
  input  logic [LBL_W-2:0] ofs_nxt,
  input  logic [LBL_W-1:0] rnd,
  input  logic [LBL_W-1:0] a_zero,
  input  logic [LBL_W-1:0] a_one,
  input  logic [LBL_W-1:0] b_zero,
  input  logic [LBL_W-1:0] b_one,
  output logic [LBL_W-1:0] res_zero,
  output logic [LBL_W-1:0] res_one,
  output logic             has_lbl
);
  always_comb begin
    res_zero = '0;
    res_one  = '0;
    has_lbl  = 1'b0;
    case (op)
      OP_NEW: begin
        res_one  = rnd;
        res_zero = rnd ^ {ofs_cur, 1'b1};
        has_lbl  = 1'b1;
      end
      OP_XOR: begin
        res_zero = a_zero ^ b_zero;
        res_one  = a_zero ^ b_one;
        has_lbl  = 1'b1;
      end
      OP_UPD: begin
        res_zero = a_zero;
        res_one  = a_zero ^ {ofs_nxt, 1'b1};
        has_lbl  = 1'b1;
      end
      OP_READ: begin
        res_zero = a_zero;
        res_one  = a_one;
        has_lbl  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wl_label_unit.sv
module wl_label_unit
  import wl_pkg::*;
#(
  parameter int LBL_W     = 128,
  parameter int WID_W     = 16,
  parameter int NUM_WIRES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [WID_W-1:0] cmd_dst,
  input  logic [WID_W-1:0] cmd_src_a,
  input  logic [WID_W-1:0] cmd_src_b,
  input  logic [LBL_W-1:0] rand_word,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_err,
  output logic [LBL_W-1:0] rsp_zero,
  output logic [LBL_W-1:0] rsp_one
);
  localparam int OFS_W = LBL_W - 1;

  wl_op_e op;
  assign op = wl_op_e'(cmd_op);

  logic             accept, err, wr_en, rsp_lbl;
  logic             need_a, need_b, need_dst;
  logic             a_ok, b_ok, dst_ok, has_lbl;
  logic [LBL_W-1:0] a_z, a_o, b_z, b_o, res_z, res_o;
  logic [OFS_W-1:0] ofs_cur, ofs_nxt;

  assign cmd_ready = !rsp_valid;
  assign accept    = cmd_valid && cmd_ready;

  assign need_a   = (op == OP_XOR) || (op == OP_UPD) || (op == OP_READ);
  assign need_b   = (op == OP_XOR);
  assign need_dst = (op == OP_NEW) || (op == OP_XOR) || (op == OP_UPD);
  assign err      = (need_a && !a_ok) || (need_b && !b_ok) || (need_dst && !dst_ok);
  assign wr_en    = accept && need_dst && !err;

  wl_offsets #(.OFS_W(OFS_W)) u_ofs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_cur  (accept && op == OP_LDC),
    .ld_nxt  (accept && op == OP_LDN),
    .promote (accept && op == OP_PROM),
    .ld_val  (rand_word[LBL_W-1:1]),
    .cur     (ofs_cur),
    .nxt     (ofs_nxt)
  );

  wl_store #(.LBL_W(LBL_W), .WID_W(WID_W), .NUM_WIRES(NUM_WIRES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .ra_id       (cmd_src_a),
    .rb_id       (cmd_src_b),
    .wr_id       (cmd_dst),
    .wr_en       (wr_en),
    .wr_zero     (res_z),
    .wr_one      (res_o),
    .ra_ok       (a_ok),
    .ra_zero     (a_z),
    .ra_one      (a_o),
    .rb_ok       (b_ok),
    .rb_zero     (b_z),
    .rb_one      (b_o),
    .wr_in_range (dst_ok)
  );

  wl_alu #(.LBL_W(LBL_W)) u_alu (
    .op       (op),
    .ofs_cur  (ofs_cur),
    .ofs_nxt  (ofs_nxt),
    .rnd      (rand_word),
    .a_zero   (a_z),
    .a_one    (a_o),
    .b_zero   (b_z),
    .b_one    (b_o),
    .res_zero (res_z),
    .res_one  (res_o),
    .has_lbl  (has_lbl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_lbl   <= 1'b0;
      rsp_zero  <= '0;
      rsp_one   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= err;
      rsp_lbl   <= has_lbl && !err;
      rsp_zero  <= err ? '0 : res_z;
      rsp_one   <= err ? '0 : res_o;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: fixed one-cycle latency
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);

  // R9: response frozen under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_err)
      && $stable(rsp_zero) && $stable(rsp_one));

  // R11: labels of a pair differ in the select bit
  a_r11_select: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_lbl) |-> (rsp_zero[0] != rsp_one[0]));

  // R7: a rejected response carries no label data
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_zero == '0) && (rsp_one == '0));
endmodule

// File: tb/wl_label_unit_bench.sv
module wl_label_unit_bench;
  localparam int NW = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_op = '0;
  logic [15:0]  cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
  logic [127:0] rand_word = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic         rsp_err;
  logic [127:0] rsp_zero, rsp_one;

  always #2ns clk = ~clk;

  wl_label_unit u_wl_label_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a),
    .cmd_src_b(cmd_src_b), .rand_word(rand_word), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_zero(rsp_zero),
    .rsp_one(rsp_one)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit exp_rv = 0;

  // reference model state
  logic [127:0] mz [NW];
  logic [127:0] mo [NW];
  bit           mv [NW];
  logic [126:0] m_cur = '0, m_nxt = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of handshake pins against the model (R8)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rsp_valid == exp_rv, "R8 rsp_valid", 128'(rsp_valid), 128'(exp_rv));
      chk(cmd_ready == !exp_rv, "R8 cmd_ready", 128'(cmd_ready), 128'(!exp_rv));
    end
  end

  task automatic model(input logic [2:0] op, input logic [15:0] d, a, b,
                       input logic [127:0] rn, output bit e_err,
                       output logic [127:0] ez, output logic [127:0] eo);
    bit aok, bok, dok;
    aok = (a < NW) && mv[a[5:0]];
    bok = (b < NW) && mv[b[5:0]];
    dok = (d < NW);
    e_err = 0; ez = '0; eo = '0;
    case (op)
      3'd0: if (!aok) e_err = 1; else begin ez = mz[a[5:0]]; eo = mo[a[5:0]]; end
      3'd1: if (!dok) e_err = 1; else begin eo = rn; ez = rn ^ {m_cur, 1'b1}; end
      3'd2: if (!aok || !bok || !dok) e_err = 1;
            else begin ez = mz[a[5:0]] ^ mz[b[5:0]]; eo = mz[a[5:0]] ^ mo[b[5:0]]; end
      3'd3: if (!aok || !dok) e_err = 1;
            else begin ez = mz[a[5:0]]; eo = mz[a[5:0]] ^ {m_nxt, 1'b1}; end
      3'd4: m_cur = rn[127:1];
      3'd5: m_nxt = rn[127:1];
      3'd6: begin m_cur = m_nxt; m_nxt = '0; end
      default: ;
    endcase
    if (!e_err && (op == 3'd1 || op == 3'd2 || op == 3'd3)) begin
      mz[d[5:0]] = ez; mo[d[5:0]] = eo; mv[d[5:0]] = 1;
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] d, a, b,
                       input logic [127:0] rn, input int hold, input string req);
    bit e_err;
    logic [127:0] ez, eo;
    @(negedge clk);
    cmd_op = op; cmd_dst = d; cmd_src_a = a; cmd_src_b = b; rand_word = rn;
    cmd_valid = 1;
    model(op, d, a, b, rn, e_err, ez, eo);
    @(posedge clk);
    #1 cmd_valid = 0;
    exp_rv = 1;
    for (int h = 0; h <= hold; h++) begin
      @(negedge clk);
      chk(rsp_err == e_err, {req, " err"}, 128'(rsp_err), 128'(e_err));
      chk(rsp_zero == ez, {req, " zero"}, rsp_zero, ez);
      chk(rsp_one == eo, {req, " one"}, rsp_one, eo);
    end
    rsp_ready = 1;
    @(posedge clk);
    #1 rsp_ready = 0;
    exp_rv = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: idle after reset, nothing written
    chk(cmd_ready == 1, "R1 ready", 128'(cmd_ready), 128'(1));
    chk(rsp_valid == 0, "R1 valid", 128'(rsp_valid), 128'(0));
    issue(3'd0, 0, 0, 0, '0, 0, "R1 read unwritten");
    // R2 with zero offset
    issue(3'd1, 0, 0, 0, {4{32'h1357_9BDF}}, 0, "R2 new zero-offset");
    // R5 load current, then R2 new wires using it
    issue(3'd4, 0, 0, 0, {4{32'hC0FF_EE11}}, 0, "R5 load cur");
    issue(3'd1, 1, 0, 0, {4{32'h8421_0F0E}}, 0, "R5 R2 new w1");
    issue(3'd1, 2, 0, 0, {4{32'h5A5A_A5A3}}, 0, "R2 new w2");
    issue(3'd0, 0, 1, 0, '0, 0, "R10 read w1");
    // R3 with back-pressure R9
    issue(3'd2, 3, 1, 2, '0, 3, "R3 R9 xor");
    issue(3'd2, 6, 2, 2, '0, 0, "R3 xor self");
    // R7 rejections and proof of no write
    issue(3'd2, 7, 1, 10, '0, 0, "R7 xor unwritten src");
    issue(3'd0, 0, 7, 0, '0, 0, "R7 dst untouched");
    issue(3'd1, 16'd64, 0, 0, {4{32'hFFFF_0001}}, 0, "R7 dst out of range");
    issue(3'd1, 16'd63, 0, 0, {4{32'h0BAD_F00D}}, 0, "R2 last id");
    issue(3'd0, 0, 16'd200, 0, '0, 0, "R7 src out of range");
    // R4 update with next offset, R6 promotion
    issue(3'd5, 0, 0, 0, {4{32'h7E57_AB1E}}, 0, "R5 load next");
    issue(3'd3, 4, 3, 0, '0, 0, "R4 update");
    issue(3'd6, 0, 0, 0, '0, 0, "R6 promote");
    issue(3'd1, 5, 0, 0, {4{32'h2468_ACE0}}, 0, "R6 new uses promoted");
    issue(3'd3, 8, 4, 0, '0, 0, "R6 update with cleared next");
    issue(3'd2, 9, 4, 5, '0, 2, "R3 xor after promote");
    issue(3'd7, 9, 0, 0, {4{32'h1111_2222}}, 0, "R10 nop");
    issue(3'd0, 0, 9, 0, '0, 0, "R10 read w9");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule